// File: doc/BRIEF.md
# Serial Front-End Packet Input Channel

This block takes one serial bit stream from a front-end readout chip and turns it into 64-bit packets. The stream is qualified bit by bit, so the 160 Mbps link can be sampled in a faster core clock domain, with a bit-valid strobe marking each real bit. Each finished packet is sorted by a two-bit type code in its top bits into one of three classes: detector-readout data, regional-request data, or register-read responses. A packet with an unused code is dropped and counted.

Readout and regional packets share one 128-entry, 64-bit buffer memory. The memory is split into two halves, and each half works as a circular queue for one class. Register responses go to a separate four-entry FIFO that software-side logic pops directly. A drain controller moves buffered packets to a downstream framing stage as four 16-bit words. Each class has its own advance input and its own completion pulse. Regional packets are served first, and the words of two packets are never mixed.

Top module: `ich_input_channel`

## Requirements
- R1: Serial bits are taken only in cycles where `ser_vld` is high; `ser_in` is ignored otherwise. The first accepted bit of a packet becomes bit 63, and every 64th accepted bit completes a packet.
- R2: A completed packet is classed by its bits [63:62]: 2'b01 is readout (L1), 2'b10 is regional (R3), and 2'b11 is a register response.
- R3: A packet with code 2'b00, or a register response that arrives while the register FIFO holds 4 entries, is discarded, and `drop_cnt` increments by one. `drop_cnt` saturates at its maximum value (255 by default).
- R4: Each class owns 64 memory slots. A packet of that class that arrives while all of its slots are occupied is discarded, and that class's overflow flag (`l1_ovf` or `r3_ovf`) is set. The flag stays set until reset.
- R5: Register responses pass through a 4-deep first-in first-out queue. `reg_data` shows the oldest entry whenever `reg_empty` is low, and `reg_rd` removes that entry.
- R6: A buffered packet is presented as four 16-bit words on `out_data` with `out_vld` high, bits [63:48] first. A word advances only at a clock edge where the advance input of the packet's class (`l1_next` or `r3_next`) is high. Until then, `out_data` and `out_r3` hold their values.
- R7: One cycle after the fourth word of a packet is accepted, the completion output of that packet's class (`l1_done` or `r3_done`) is high for exactly one cycle.
- R8: When the controller starts a new packet and both classes have packets buffered, it takes the regional packet. `out_r3` is 1 for regional packets and 0 for readout packets. `out_r3` stays constant while `out_vld` stays high.
- R9: Within a class, packets leave in the order they arrived.
- R10: After reset, `out_vld`, both completion outputs and both overflow flags are 0, `drop_cnt` is 0, and `reg_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit from the front-end chip |
| ser_vld | input | 1 | Marks `ser_in` as a real bit this cycle |
| l1_next | input | 1 | Downstream accepts the current readout word |
| r3_next | input | 1 | Downstream accepts the current regional word |
| reg_rd | input | 1 | Pops the oldest register response |
| out_data | output | 16 | Current output word |
| out_vld | output | 1 | `out_data` holds a valid word |
| out_r3 | output | 1 | Class of the current packet (1 = regional) |
| l1_done | output | 1 | Readout packet completed (one-cycle pulse) |
| r3_done | output | 1 | Regional packet completed (one-cycle pulse) |
| reg_data | output | 64 | Oldest register response |
| reg_empty | output | 1 | Register FIFO holds no entry |
| l1_ovf | output | 1 | Sticky: a readout packet was lost because its region was full |
| r3_ovf | output | 1 | Sticky: a regional packet was lost because its region was full |
| drop_cnt | output | 8 | Saturating count of discarded packets |

## Verification
A misaligned bit counter in the deserializer changes the first packet's class code or word contents. The error appears on `out_data` about two cycles after the 64th bit. A queue pointer or occupancy error in the memory shows up as a reordered, repeated or missing packet, or as an overflow flag set too early or too late. The error becomes visible when that class's next packet is drained. Because of this, the reference model is compared with every output on every clock, and the overflow run fills a region exactly to its edge before draining it completely.

// File: rtl/ich_pkg.sv
package ich_pkg;

  typedef enum logic [1:0] {
    CLS_NONE = 2'b00,
    CLS_L1   = 2'b01,
    CLS_R3   = 2'b10,
    CLS_REG  = 2'b11
  } pkt_cls_e;

  // Class taken from the two top bits of a packet
  function automatic pkt_cls_e pkt_class(input logic [1:0] code);
    return pkt_cls_e'(code);
  endfunction

  // Saturating increment for an 8-bit counter
  function automatic logic [7:0] sat_inc8(input logic [7:0] v);
    return (v == 8'hFF) ? v : v + 8'd1;
  endfunction

endpackage

// File: rtl/ich_deser.sv
module ich_deser #(
  parameter int PKT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  output logic             pkt_vld,
  output logic [PKT_W-1:0] pkt_data
);
  localparam int BW = $clog2(PKT_W);
  localparam logic [BW-1:0] LAST = BW'(PKT_W - 1);

  logic [PKT_W-1:0] sr;
  logic [BW-1:0]    bcnt;
  logic [PKT_W-1:0] nxt;

  assign nxt = {sr[PKT_W-2:0], bit_in};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      bcnt     <= '0;
      pkt_vld  <= 1'b0;
      pkt_data <= '0;
    end else begin
      pkt_vld <= 1'b0;
      if (bit_vld) begin
        sr <= nxt;
        if (bcnt == LAST) begin
          bcnt     <= '0;
          pkt_vld  <= 1'b1;
          pkt_data <= nxt;
        end else begin
          bcnt <= bcnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ich_region_mem.sv
module ich_region_mem #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 128
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic                                      wr_en,
  input  logic                                      wr_sel,
  input  logic [DATA_W-1:0]                         wr_data,
  input  logic                                      rd_en,
  input  logic                                      rd_sel,
  output logic [DATA_W-1:0]                         rd_data,
  output logic [1:0][$clog2(DEPTH/2):0]             cnt_o,
  output logic [1:0]                                ovf_o
);
  localparam int REGION = DEPTH / 2;
  localparam int RAW    = $clog2(REGION);
  localparam int CW     = RAW + 1;

  logic [DATA_W-1:0]    mem [DEPTH];
  logic [1:0][RAW-1:0]  wp_all;
  logic [1:0][RAW-1:0]  rp_all;
  logic [1:0]           push_all;

  for (genvar g = 0; g < 2; g++) begin : g_region
    logic [RAW-1:0] wp, rp;
    logic [CW-1:0]  cnt;
    logic           ovf;
    logic           full, wr_hit, push, pop;

    assign full   = (cnt == CW'(REGION));
    assign wr_hit = wr_en && (wr_sel == 1'(g));
    assign push   = wr_hit && !full;
    assign pop    = rd_en && (rd_sel == 1'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
        ovf <= 1'b0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(pop);
        if (wr_hit && full) ovf <= 1'b1;
      end
    end

    assign wp_all[g]   = wp;
    assign rp_all[g]   = rp;
    assign push_all[g] = push;
    assign cnt_o[g]    = cnt;
    assign ovf_o[g]    = ovf;
  end

  always_ff @(posedge clk) begin
    if (|push_all) mem[{wr_sel, wp_all[wr_sel]}] <= wr_data;
  end

  assign rd_data = mem[{rd_sel, rp_all[rd_sel]}];
endmodule

// File: rtl/ich_reg_fifo.sv
module ich_reg_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = slot[rp];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot[wp] <= din;
  end
endmodule

// File: rtl/ich_drain_ctrl.sv
module ich_drain_ctrl #(
  parameter int PKT_W = 64,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l1_pend,
  input  logic             r3_pend,
  input  logic [PKT_W-1:0] rd_data,
  input  logic             l1_next,
  input  logic             r3_next,
  output logic             rd_en,
  output logic             rd_sel,
  output logic [OUT_W-1:0] out_data,
  output logic             out_vld,
  output logic             out_r3,
  output logic             l1_done,
  output logic             r3_done,
  output logic             word_acc
);
  localparam int WPP = PKT_W / OUT_W;
  localparam int IW  = $clog2(WPP);

  logic             busy, cls;
  logic [IW-1:0]    idx;
  logic [PKT_W-1:0] hold;
  logic             last;

  assign rd_en    = !busy && (l1_pend || r3_pend);
  assign rd_sel   = r3_pend;
  assign word_acc = busy && (cls ? r3_next : l1_next);
  assign last     = (idx == IW'(WPP - 1));
  assign out_vld  = busy;
  assign out_r3   = cls;
  assign out_data = hold[PKT_W - 1 - int'(idx) * OUT_W -: OUT_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cls     <= 1'b0;
      idx     <= '0;
      hold    <= '0;
      l1_done <= 1'b0;
      r3_done <= 1'b0;
    end else begin
      l1_done <= 1'b0;
      r3_done <= 1'b0;
      if (rd_en) begin
        hold <= rd_data;
        cls  <= rd_sel;
        idx  <= '0;
        busy <= 1'b1;
      end else if (word_acc) begin
        idx <= idx + 1'b1;
        if (last) begin
          busy    <= 1'b0;
          l1_done <= !cls;
          r3_done <= cls;
        end
      end
    end
  end
endmodule

// File: rtl/ich_input_channel.sv
module ich_input_channel
  import ich_pkg::*;
#(
  parameter int PKT_W     = 64,
  parameter int OUT_W     = 16,
  parameter int MEM_DEPTH = 128,
  parameter int REG_DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             ser_vld,
  input  logic             l1_next,
  input  logic             r3_next,
  input  logic             reg_rd,
  output logic [OUT_W-1:0] out_data,
  output logic             out_vld,
  output logic             out_r3,
  output logic             l1_done,
  output logic             r3_done,
  output logic [PKT_W-1:0] reg_data,
  output logic             reg_empty,
  output logic             l1_ovf,
  output logic             r3_ovf,
  output logic [7:0]       drop_cnt
);
  localparam int REGION = MEM_DEPTH / 2;
  localparam int CW     = $clog2(REGION) + 1;

  logic             pkt_vld;
  logic [PKT_W-1:0] pkt_data;
  pkt_cls_e         cls;
  logic             mem_wr, mem_sel, rd_en, rd_sel;
  logic [PKT_W-1:0] rd_data;
  logic [1:0][CW-1:0] cnt;
  logic [1:0]       ovf;
  logic             reg_full, reg_push, drop_evt, word_acc;
  logic [CW-1:0]    l1_cnt, r3_cnt;

  ich_deser #(.PKT_W(PKT_W)) u_deser (
    .clk(clk), .rst(rst), .bit_in(ser_in), .bit_vld(ser_vld),
    .pkt_vld(pkt_vld), .pkt_data(pkt_data)
  );

  assign cls      = pkt_class(pkt_data[PKT_W-1 -: 2]);
  assign mem_wr   = pkt_vld && (cls == CLS_L1 || cls == CLS_R3);
  assign mem_sel  = (cls == CLS_R3);
  assign reg_push = pkt_vld && (cls == CLS_REG);
  assign drop_evt = pkt_vld && ((cls == CLS_NONE) || (cls == CLS_REG && reg_full));

  ich_region_mem #(.DATA_W(PKT_W), .DEPTH(MEM_DEPTH)) u_mem (
    .clk(clk), .rst(rst), .wr_en(mem_wr), .wr_sel(mem_sel), .wr_data(pkt_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .cnt_o(cnt), .ovf_o(ovf)
  );

  assign l1_cnt = cnt[0];
  assign r3_cnt = cnt[1];
  assign l1_ovf = ovf[0];
  assign r3_ovf = ovf[1];

  ich_reg_fifo #(.W(PKT_W), .DEPTH(REG_DEPTH)) u_regq (
    .clk(clk), .rst(rst), .push(reg_push), .pop(reg_rd), .din(pkt_data),
    .dout(reg_data), .empty(reg_empty), .full(reg_full)
  );

  ich_drain_ctrl #(.PKT_W(PKT_W), .OUT_W(OUT_W)) u_drain (
    .clk(clk), .rst(rst), .l1_pend(l1_cnt != '0), .r3_pend(r3_cnt != '0),
    .rd_data(rd_data), .l1_next(l1_next), .r3_next(r3_next),
    .rd_en(rd_en), .rd_sel(rd_sel), .out_data(out_data), .out_vld(out_vld),
    .out_r3(out_r3), .l1_done(l1_done), .r3_done(r3_done), .word_acc(word_acc)
  );

  always_ff @(posedge clk) begin
    if (rst) drop_cnt <= '0;
    else if (drop_evt) drop_cnt <= sat_inc8(drop_cnt);
  end
endmodule

// File: rtl/ich_input_channel_chk.sv
module ich_input_channel_chk #(
  parameter int OUT_W  = 16,
  parameter int CW     = 7,
  parameter int REGION = 64
) (
  input logic             clk,
  input logic             rst,
  input logic [OUT_W-1:0] out_data,
  input logic             out_vld,
  input logic             out_r3,
  input logic             l1_next,
  input logic             r3_next,
  input logic             l1_done,
  input logic             r3_done,
  input logic             l1_ovf,
  input logic             r3_ovf,
  input logic [7:0]       drop_cnt,
  input logic [CW-1:0]    l1_cnt,
  input logic [CW-1:0]    r3_cnt,
  input logic             word_acc
);
  // R6
  word_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !word_acc) |=> (out_vld && $stable(out_data) && $stable(out_r3)));

  // R6
  acc_needs_next_chk: assert property (@(posedge clk) disable iff (rst)
    word_acc |-> (out_vld && (out_r3 ? r3_next : l1_next)));

  // R8
  no_interleave_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && $past(out_vld)) |-> (out_r3 == $past(out_r3)));

  // R7
  done_one_class_chk: assert property (@(posedge clk) disable iff (rst)
    !(l1_done && r3_done));

  // R7
  l1_done_src_chk: assert property (@(posedge clk) disable iff (rst)
    l1_done |-> $past(out_vld && !out_r3 && l1_next));

  // R7
  r3_done_src_chk: assert property (@(posedge clk) disable iff (rst)
    r3_done |-> $past(out_vld && out_r3 && r3_next));

  // R4
  l1_ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    l1_ovf |=> l1_ovf);

  // R4
  r3_ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    r3_ovf |=> r3_ovf);

  // R4
  region_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (l1_cnt <= CW'(REGION)) && (r3_cnt <= CW'(REGION)));

  // R3
  drop_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt != 8'hFF) |=> (drop_cnt >= $past(drop_cnt)));

  // R3
  drop_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (drop_cnt == 8'hFF) |=> (drop_cnt == 8'hFF));
endmodule

bind ich_input_channel ich_input_channel_chk #(
  .OUT_W(OUT_W), .CW(CW), .REGION(REGION)
) u_chk (
  .clk(clk), .rst(rst), .out_data(out_data), .out_vld(out_vld), .out_r3(out_r3),
  .l1_next(l1_next), .r3_next(r3_next), .l1_done(l1_done), .r3_done(r3_done),
  .l1_ovf(l1_ovf), .r3_ovf(r3_ovf), .drop_cnt(drop_cnt),
  .l1_cnt(l1_cnt), .r3_cnt(r3_cnt), .word_acc(word_acc)
);

// File: tb/test_ich_input_channel.sv
module test_ich_input_channel;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ser_in = 1'b0, ser_vld = 1'b0;
  logic        l1_next = 1'b0, r3_next = 1'b0, reg_rd = 1'b0;
  logic [15:0] out_data;
  logic        out_vld, out_r3, l1_done, r3_done, reg_empty, l1_ovf, r3_ovf;
  logic [63:0] reg_data;
  logic [7:0]  drop_cnt;

  int checks = 0, fails = 0, cycles = 0;
  bit toggle_next = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ich_input_channel i_ich_input_channel (
    .clk(clk), .rst(rst), .ser_in(ser_in), .ser_vld(ser_vld),
    .l1_next(l1_next), .r3_next(r3_next), .reg_rd(reg_rd),
    .out_data(out_data), .out_vld(out_vld), .out_r3(out_r3),
    .l1_done(l1_done), .r3_done(r3_done), .reg_data(reg_data),
    .reg_empty(reg_empty), .l1_ovf(l1_ovf), .r3_ovf(r3_ovf), .drop_cnt(drop_cnt)
  );

  // ---------------- behavioural reference ----------------
  logic [63:0] q_l1[$], q_r3[$], q_reg[$];
  logic [63:0] m_sr, m_pkt, m_hold;
  int          m_bits, m_idx, m_drop;
  bit          m_pv, m_busy, m_cls, m_l1d, m_r3d, m_l1o, m_r3o;
  int          n_l1, n_r3, n_rg;
  bit          pv;
  logic [63:0] pk;

  always @(posedge clk) begin
    if (rst) begin
      q_l1.delete(); q_r3.delete(); q_reg.delete();
      m_sr = '0; m_pkt = '0; m_hold = '0; m_bits = 0; m_idx = 0; m_drop = 0;
      m_pv = 0; m_busy = 0; m_cls = 0; m_l1d = 0; m_r3d = 0; m_l1o = 0; m_r3o = 0;
    end else begin
      n_l1 = q_l1.size(); n_r3 = q_r3.size(); n_rg = q_reg.size();
      pv = m_pv; pk = m_pkt;
      m_l1d = 0; m_r3d = 0;
      if (!m_busy) begin
        if (n_r3 > 0) begin m_hold = q_r3.pop_front(); m_cls = 1; m_busy = 1; m_idx = 0; end
        else if (n_l1 > 0) begin m_hold = q_l1.pop_front(); m_cls = 0; m_busy = 1; m_idx = 0; end
      end else if (m_cls ? r3_next : l1_next) begin
        if (m_idx == 3) begin
          m_busy = 0;
          if (m_cls) m_r3d = 1; else m_l1d = 1;
        end else m_idx++;
      end
      if (reg_rd && n_rg > 0) void'(q_reg.pop_front());
      if (pv) begin
        case (pk[63:62])
          2'b01: if (n_l1 < 64) q_l1.push_back(pk); else m_l1o = 1;
          2'b10: if (n_r3 < 64) q_r3.push_back(pk); else m_r3o = 1;
          2'b11: if (n_rg < 4) q_reg.push_back(pk); else if (m_drop < 255) m_drop++;
          default: if (m_drop < 255) m_drop++;
        endcase
      end
      m_pv = 0;
      if (ser_vld) begin
        if (m_bits == 63) begin m_pv = 1; m_pkt = {m_sr[62:0], ser_in}; m_bits = 0; end
        else m_bits++;
        m_sr = {m_sr[62:0], ser_in};
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(out_vld == m_busy, "R6 R8 out_vld", 64'(out_vld), 64'(m_busy));
      if (m_busy) begin
        chk(out_data == m_hold[63 - m_idx*16 -: 16], "R1 R2 R6 R9 out_data",
            64'(out_data), 64'(m_hold[63 - m_idx*16 -: 16]));
        chk(out_r3 == m_cls, "R2 R8 out_r3", 64'(out_r3), 64'(m_cls));
      end
      chk(l1_done == m_l1d, "R7 l1_done", 64'(l1_done), 64'(m_l1d));
      chk(r3_done == m_r3d, "R7 r3_done", 64'(r3_done), 64'(m_r3d));
      chk(reg_empty == (q_reg.size() == 0), "R5 reg_empty", 64'(reg_empty), 64'(q_reg.size() == 0));
      if (q_reg.size() > 0) chk(reg_data == q_reg[0], "R5 reg_data", reg_data, q_reg[0]);
      chk(l1_ovf == m_l1o, "R4 l1_ovf", 64'(l1_ovf), 64'(m_l1o));
      chk(r3_ovf == m_r3o, "R4 r3_ovf", 64'(r3_ovf), 64'(m_r3o));
      chk(drop_cnt == 8'(m_drop), "R3 drop_cnt", 64'(drop_cnt), 64'(m_drop));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > WD_LIMIT) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WD_LIMIT);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic set_next(input int i);
    if (toggle_next) begin
      l1_next = (i % 3) != 0;
      r3_next = (i % 2) == 0;
    end
  endtask

  // R1: idle gaps insert cycles with ser_vld low and a garbage bit
  task automatic send(input logic [63:0] w, input int gap);
    for (int i = 63; i >= 0; i--) begin
      if (gap > 0 && (i % gap) == 0) begin
        @(negedge clk); ser_vld = 1'b0; ser_in = ~w[i]; set_next(i);
      end
      @(negedge clk); ser_in = w[i]; ser_vld = 1'b1; set_next(i);
    end
    @(negedge clk); ser_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ser_vld = 1'b0; set_next(k);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(out_vld == 0 && l1_done == 0 && r3_done == 0, "R10 outputs idle", 64'(out_vld), 0);
    chk(l1_ovf == 0 && r3_ovf == 0, "R10 flags clear", 64'({l1_ovf, r3_ovf}), 0);
    chk(drop_cnt == 0 && reg_empty == 1, "R10 counters", 64'({drop_cnt, reg_empty}), 64'h1);

    // basic traffic, downstream always ready
    l1_next = 1; r3_next = 1;
    send(64'h4123_4567_89AB_CDEF, 0);
    send(64'h8FED_CBA9_8765_4321, 5);
    send(64'h0000_1111_2222_3333, 7);   // unknown class
    idle(12);
    chk(drop_cnt == 8'd1, "R3 unknown dropped", 64'(drop_cnt), 1);

    // register responses: five arrive, four kept
    for (int p = 0; p < 5; p++) send(64'hC000_0000_0000_0A00 + 64'(p), 0);
    idle(4);
    chk(reg_empty == 0, "R5 reg stored", 64'(reg_empty), 0);
    chk(drop_cnt == 8'd2, "R3 reg full drop", 64'(drop_cnt), 2);
    for (int p = 0; p < 4; p++) begin
      @(negedge clk); chk(reg_data == 64'hC000_0000_0000_0A00 + 64'(p), "R5 reg order",
                          reg_data, 64'hC000_0000_0000_0A00 + 64'(p));
      reg_rd = 1; @(negedge clk); reg_rd = 0;
    end
    idle(2);
    chk(reg_empty == 1, "R5 reg drained", 64'(reg_empty), 1);

    // R8 priority: stall, queue L1 A (taken into output), L1 B, R3 C
    l1_next = 0; r3_next = 0;
    send(64'h4AAA_0001_0002_0003, 0);
    send(64'h4BBB_0004_0005_0006, 3);
    send(64'h8CCC_0007_0008_0009, 0);
    idle(6);
    chk(out_vld == 1 && out_r3 == 0 && out_data == 16'h4AAA, "R6 stalled head",
        64'(out_data), 64'h4AAA);
    l1_next = 1; r3_next = 1;
    idle(30);

    // stuttering advance, mixed classes
    toggle_next = 1;
    send(64'h4111_2222_3333_4444, 4);
    send(64'h8555_6666_7777_8888, 0);
    send(64'h4999_AAAA_BBBB_CCCC, 6);
    idle(40);
    toggle_next = 0; l1_next = 1; r3_next = 1;

    // drop counter saturation
    for (int p = 0; p < 258; p++) send(64'h0000_0000_0000_0000 + 64'(p), 0);
    idle(4);
    chk(drop_cnt == 8'hFF, "R3 saturate", 64'(drop_cnt), 64'hFF);

    // R4 region overflow: 66 L1 packets with no drain
    l1_next = 0;
    for (int p = 0; p < 66; p++) send(64'h4000_0000_0000_0000 + 64'(p), 0);
    idle(4);
    chk(l1_ovf == 1, "R4 l1 overflow", 64'(l1_ovf), 1);
    chk(r3_ovf == 0, "R4 r3 untouched", 64'(r3_ovf), 0);
    l1_next = 1;
    idle(400);
    chk(out_vld == 0, "R9 fully drained", 64'(out_vld), 0);
    chk(l1_ovf == 1, "R4 flag sticky", 64'(l1_ovf), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule